// File: doc/BRIEF.md
# UART FIFO Trigger Control Unit

This block holds the FIFO control register of a UART that has separate transmit and receive FIFOs. A bus write carries an enable bit, a DMA mode bit, two flush bits and two 2-bit trigger codes. Each field is accepted only under its own write gate. One field needs the enhanced-feature input. Another group needs the baud divisor to be zero. A flush request drives a one-cycle flush pulse to the matching FIFO, and the request bits themselves are never stored. Two byte FIFOs are built in, so the unit can be exercised on its own. Each FIFO holds one byte while FIFOs are disabled and 64 bytes while they are enabled.

A small flush state machine has four states: FL_IDLE, FL_RX, FL_TX and FL_BOTH. On every clock it moves to the state named by the flush requests of the current write, or to FL_IDLE when there is no request. The transitions are IDLE→RX, IDLE→TX, IDLE→BOTH, any flush state→IDLE, and any state→any flush state on a new request. A receive flush is requested by write bit 1. A transmit flush is requested by write bit 2. A change of the enable bit requests both.

Receive and transmit thresholds are picked from one of three sources: a code table, a coarse override nibble, or a fine 6-bit value. Registered flags compare the receive fill level and the transmit free space against these thresholds. The flags drive two active-low DMA request lines.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: After reset, fifo_on is 0, rx_level is 0, tx_free is 1, both flags are 0 and dma_req_n is 2'b11.
- R2: Write bits 3:0 (bit 0 enable, bit 3 DMA mode, bits 1 and 2 flush requests) take effect only while div_lo and div_hi are both zero. Otherwise fifo_on keeps its value.
- R3: The transmit code in write bits 5:4 is stored only while enh_en is 1. Otherwise the old code is kept. The receive code in bits 7:6 is always stored.
- R4: A write with bit 1 set (receive) or bit 2 set (transmit) empties that FIFO on the next clock edge. The pulse lasts one cycle unless the request is written again. A 0 in these bits has no effect.
- R5: Changing the enable bit flushes both FIFOs on the next clock edge.
- R6: With fifo_on at 0 each FIFO holds at most 1 byte. With fifo_on at 1 each holds 64 bytes, so tx_free reads 1 or 64 when the FIFO is empty.
- R7: With sup_fine_rx at 0 and rx_nib at 0, receive codes 00/01/10/11 give thresholds of 8/16/56/60.
- R8: With sup_fine_tx at 0 and tx_nib at 0, transmit codes 00/01/10/11 give thresholds of 8/16/32/56, compared against tx_free.
- R9: With fine mode off and a nonzero nibble, the threshold is nibble×4 and the 2-bit code is ignored.
- R10: With fine mode on, the threshold is {nibble, code} as a 6-bit value, and a value of 0 is treated as 1.
- R11: rx_trig is 1 when rx_level ≥ threshold, and tx_trig is 1 when tx_free ≥ threshold. Both are registered and follow a level change one cycle later.
- R12: dma_req_n[0] is low when tx_trig is 1, and dma_req_n[1] is low when rx_trig is 1. Both need the stored DMA mode bit at 1 and sup_dma_ext at 0. Otherwise both lines are high.
- R13: Each FIFO returns bytes in write order. A push into a full FIFO and a pop from an empty FIFO are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| div_lo | input | 8 | Baud divisor low byte |
| div_hi | input | 8 | Baud divisor high byte |
| enh_en | input | 1 | Enhanced-feature enable; gates the transmit code |
| sup_fine_rx | input | 1 | Fine-granularity receive threshold |
| sup_fine_tx | input | 1 | Fine-granularity transmit threshold |
| sup_dma_ext | input | 1 | DMA control taken elsewhere; masks the DMA mode bit |
| rx_nib | input | 4 | Receive threshold nibble |
| tx_nib | input | 4 | Transmit threshold nibble |
| rx_push | input | 1 | Write a byte into the receive FIFO |
| rx_data | input | DATA_W | Receive FIFO write data |
| rx_pop | input | 1 | Read a byte from the receive FIFO |
| rx_q | output | DATA_W | Receive FIFO head |
| tx_push | input | 1 | Write a byte into the transmit FIFO |
| tx_data | input | DATA_W | Transmit FIFO write data |
| tx_pop | input | 1 | Read a byte from the transmit FIFO |
| tx_q | output | DATA_W | Transmit FIFO head |
| fifo_on | output | 1 | Stored FIFO enable |
| rx_level | output | CNT_W | Receive fill count |
| tx_free | output | CNT_W | Transmit free space |
| rx_trig | output | 1 | Receive threshold flag |
| tx_trig | output | 1 | Transmit threshold flag |
| dma_req_n | output | 2 | Active-low DMA requests (0 transmit, 1 receive) |

## Verification
The checks assume two things about the inputs. First, a write that changes the enable bit or requests a flush is not followed on the next cycle by another write, so the flush pulse is seen as a single cycle. Second, the divisor and enhanced-feature inputs stay steady around each write. The bench changes these inputs only between writes and leaves at least one idle cycle after every write. It pushes receive data only while it holds the expected count, so every accepted byte is known to the scoreboard.

// File: rtl/uft_pkg.sv
package uft_pkg;

    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_RX   = 2'd1,
        FL_TX   = 2'd2,
        FL_BOTH = 2'd3
    } flush_state_t;

    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       dma_sel;
        logic       fifo_on;
    } ctrl_t;

endpackage

// File: rtl/uft_regs.sv
module uft_regs
    import uft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       div_zero,
    input  logic       enh_en,
    output ctrl_t      ctrl,
    output logic       rx_flush,
    output logic       tx_flush
);

    flush_state_t state_q, state_d;
    logic         wr_low, toggle, want_rx, want_tx;

    assign wr_low  = cfg_we && div_zero;
    assign toggle  = wr_low && (cfg_wdata[0] != ctrl.fifo_on);
    assign want_rx = (wr_low && cfg_wdata[1]) || toggle;
    assign want_tx = (wr_low && cfg_wdata[2]) || toggle;

    always_comb begin
        if (want_rx && want_tx)
            state_d = FL_BOTH;
        else if (want_rx)
            state_d = FL_RX;
        else if (want_tx)
            state_d = FL_TX;
        else
            state_d = FL_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FL_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FL_IDLE: begin rx_flush = 1'b0; tx_flush = 1'b0; end
            FL_RX:   begin rx_flush = 1'b1; tx_flush = 1'b0; end
            FL_TX:   begin rx_flush = 1'b0; tx_flush = 1'b1; end
            FL_BOTH: begin rx_flush = 1'b1; tx_flush = 1'b1; end
            default: begin rx_flush = 1'b0; tx_flush = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (cfg_we) begin
            ctrl.rx_code <= cfg_wdata[7:6];
            if (enh_en)
                ctrl.tx_code <= cfg_wdata[5:4];
            if (div_zero) begin
                ctrl.dma_sel <= cfg_wdata[3];
                ctrl.fifo_on <= cfg_wdata[0];
            end
        end
    end

endmodule

// File: rtl/uft_fifo.sv
module uft_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              deep,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cap;
    logic              push_ok, pop_ok;

    assign cap     = deep ? CNT_W'(DEPTH) : CNT_W'(1);
    assign push_ok = push && (count < cap);
    assign pop_ok  = pop && (count != '0);
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= bump(wr_ptr);
            if (pop_ok)
                rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uft_thresh.sv
module uft_thresh #(
    parameter bit IS_RX = 1'b1,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       code,
    input  logic [3:0]       nib,
    input  logic             fine,
    input  logic [CNT_W-1:0] level,
    output logic             flag
);

    localparam logic [5:0] LVL2 = IS_RX ? 6'd56 : 6'd32;
    localparam logic [5:0] LVL3 = IS_RX ? 6'd60 : 6'd56;

    logic [5:0] thr, table_thr, fine_thr;

    assign fine_thr = {nib, code};

    always_comb begin
        unique case (code)
            2'b00:   table_thr = 6'd8;
            2'b01:   table_thr = 6'd16;
            2'b10:   table_thr = LVL2;
            default: table_thr = LVL3;
        endcase
    end

    always_comb begin
        if (fine)
            thr = (fine_thr == '0) ? 6'd1 : fine_thr;
        else if (nib != 4'd0)
            thr = {nib, 2'b00};
        else
            thr = table_thr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= (level >= CNT_W'(thr));
    end

endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
    import uft_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic [7:0]        div_lo,
    input  logic [7:0]        div_hi,
    input  logic              enh_en,
    input  logic              sup_fine_rx,
    input  logic              sup_fine_tx,
    input  logic              sup_dma_ext,
    input  logic [3:0]        rx_nib,
    input  logic [3:0]        tx_nib,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_q,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_q,
    output logic              fifo_on,
    output logic [CNT_W-1:0]  rx_level,
    output logic [CNT_W-1:0]  tx_free,
    output logic              rx_trig,
    output logic              tx_trig,
    output logic [1:0]        dma_req_n
);

    ctrl_t            ctrl;
    logic             div_zero, rx_flush, tx_flush, dma_on;
    logic [1:0]       tx_code;
    logic [CNT_W-1:0] tx_cnt, cap;

    assign div_zero = (div_lo == 8'd0) && (div_hi == 8'd0);
    assign fifo_on  = ctrl.fifo_on;
    assign tx_code  = ctrl.tx_code;
    assign cap      = ctrl.fifo_on ? CNT_W'(DEPTH) : CNT_W'(1);
    assign tx_free  = cap - tx_cnt;

    uft_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .div_zero(div_zero), .enh_en(enh_en), .ctrl(ctrl),
        .rx_flush(rx_flush), .tx_flush(tx_flush)
    );

    uft_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .deep(ctrl.fifo_on),
        .push(rx_push), .din(rx_data), .pop(rx_pop), .dout(rx_q), .count(rx_level)
    );

    uft_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .deep(ctrl.fifo_on),
        .push(tx_push), .din(tx_data), .pop(tx_pop), .dout(tx_q), .count(tx_cnt)
    );

    uft_thresh #(.IS_RX(1'b1), .CNT_W(CNT_W)) u_rx_thr (
        .clk(clk), .rst_n(rst_n), .code(ctrl.rx_code), .nib(rx_nib),
        .fine(sup_fine_rx), .level(rx_level), .flag(rx_trig)
    );

    uft_thresh #(.IS_RX(1'b0), .CNT_W(CNT_W)) u_tx_thr (
        .clk(clk), .rst_n(rst_n), .code(tx_code), .nib(tx_nib),
        .fine(sup_fine_tx), .level(tx_free), .flag(tx_trig)
    );

    assign dma_on    = ctrl.dma_sel && !sup_dma_ext;
    assign dma_req_n = {~(dma_on && rx_trig), ~(dma_on && tx_trig)};

endmodule

// File: rtl/uft_chk.sv
module uft_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             enh_en,
    input logic [7:0]       div_lo,
    input logic [7:0]       div_hi,
    input logic             sup_dma_ext,
    input logic             fifo_on,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] tx_free,
    input logic             rx_flush,
    input logic             tx_flush,
    input logic [1:0]       tx_code,
    input logic [1:0]       dma_req_n
);

    // R2
    en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && ((div_lo != 8'd0) || (div_hi != 8'd0)) |=> $stable(fifo_on));

    // R3
    tx_code_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !enh_en |=> $stable(tx_code));

    // R4
    rx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_level == '0));

    // R4
    tx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush && !cfg_we |=> (tx_free == (fifo_on ? CNT_W'(DEPTH) : CNT_W'(1))));

    // R4
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush && !cfg_we |=> !rx_flush);

    // R6
    shallow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on && !rx_flush |-> (rx_level <= CNT_W'(1)));

    // R6
    deep_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= CNT_W'(DEPTH));

    // R12
    dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sup_dma_ext |-> (dma_req_n == 2'b11));

endmodule

bind fifo_trig_ctrl uft_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/fifo_trig_ctrl_bench.sv
module fifo_trig_ctrl_bench;

    localparam int DEPTH  = 64;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        div_lo = 8'd1, div_hi = 8'd0;
    logic              enh_en = 1'b0, sup_fine_rx = 1'b0, sup_fine_tx = 1'b0, sup_dma_ext = 1'b0;
    logic [3:0]        rx_nib = '0, tx_nib = '0;
    logic              rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [DATA_W-1:0] rx_data = '0, tx_data = '0;
    logic [DATA_W-1:0] rx_q, tx_q;
    logic              fifo_on, rx_trig, tx_trig;
    logic [CNT_W-1:0]  rx_level, tx_free;
    logic [1:0]        dma_req_n;

    int total = 0;
    int bad   = 0;
    int m_cnt = 0;
    bit m_en  = 1'b0;
    logic [DATA_W-1:0] exp_q[$];

    fifo_trig_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fifo_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .div_lo(div_lo), .div_hi(div_hi), .enh_en(enh_en),
        .sup_fine_rx(sup_fine_rx), .sup_fine_tx(sup_fine_tx), .sup_dma_ext(sup_dma_ext),
        .rx_nib(rx_nib), .tx_nib(tx_nib),
        .rx_push(rx_push), .rx_data(rx_data), .rx_pop(rx_pop), .rx_q(rx_q),
        .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop), .tx_q(tx_q),
        .fifo_on(fifo_on), .rx_level(rx_level), .tx_free(tx_free),
        .rx_trig(rx_trig), .tx_trig(tx_trig), .dma_req_n(dma_req_n)
    );

    always #5 clk = ~clk;

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: writes the control register and tracks the receive model
    task automatic wr(input logic [7:0] v);
        bit dz;
        dz = (div_lo == 0) && (div_hi == 0);
        cfg_wdata = v;
        cfg_we    = 1'b1;
        tick();
        cfg_we    = 1'b0;
        if (dz) begin
            if (v[1] || (v[0] != m_en)) begin
                m_cnt = 0;
                exp_q.delete();
            end
            m_en = v[0];
        end
    endtask

    task automatic rx_put(input logic [7:0] d);
        rx_data = d;
        rx_push = 1'b1;
        if (m_cnt < (m_en ? DEPTH : 1)) begin
            exp_q.push_back(d);
            m_cnt++;
        end
        tick();
        rx_push = 1'b0;
    endtask

    task automatic rx_take;
        rx_pop = 1'b1;
        if (m_cnt > 0) m_cnt--;
        tick();
        rx_pop = 1'b0;
    endtask

    // monitor: compares each popped head against the scoreboard (R13)
    always @(negedge clk) begin
        if (rst_n && rx_pop && exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk("R13 order", int'(rx_q), int'(e));
        end
    end

    initial begin
        #1500000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        chk("R1 fifo_on", fifo_on, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_free", tx_free, 1);
        chk("R1 flags", {rx_trig, tx_trig}, 0);
        chk("R1 dma", dma_req_n, 3);

        // R2: divisor nonzero blocks the enable
        wr(8'h01); tick();
        chk("R2 gated", fifo_on, 0);
        div_lo = 8'd0;
        wr(8'h01); tick();
        chk("R2 open", fifo_on, 1);
        chk("R6 deep free", tx_free, 64);

        for (int i = 0; i < 20; i++) begin
            tx_data = 8'(i); tx_push = 1'b1; tick();
        end
        tx_push = 1'b0;
        tick();
        chk("R8 free", tx_free, 44);
        chk("R8 code00", tx_trig, 1);

        // R3: transmit code locked without enh_en
        wr(8'h31); tick();
        chk("R3 locked", tx_trig, 1);
        enh_en = 1'b1;
        wr(8'h31); tick();
        chk("R8 code11", tx_trig, 0);
        wr(8'h21); tick();
        chk("R8 code10", tx_trig, 1);

        // R7 receive table
        for (int i = 0; i < 16; i++) rx_put(8'hA0 + 8'(i));
        tick();
        chk("R7 level", rx_level, 16);
        chk("R7 code00", rx_trig, 1);
        wr(8'h61); tick();
        chk("R7 code01", rx_trig, 1);
        wr(8'hA1); tick();
        chk("R7 code10", rx_trig, 0);
        wr(8'h21);
        for (int i = 0; i < 9; i++) rx_take();
        tick();
        chk("R11 below", rx_trig, 0);
        rx_put(8'h11);
        chk("R11 registered", rx_trig, 0);
        tick();
        chk("R11 at level", rx_trig, 1);

        // R9 override nibble
        wr(8'hE1); tick();
        chk("R7 code11", rx_trig, 0);
        rx_nib = 4'd2; tick();
        chk("R9 nib2", rx_trig, 1);
        rx_nib = 4'd3; tick();
        chk("R9 nib3", rx_trig, 0);

        // R10 fine mode
        sup_fine_rx = 1'b1; rx_nib = 4'd2;
        wr(8'h21); tick();
        chk("R10 thr8", rx_trig, 1);
        wr(8'h61); tick();
        chk("R10 thr9", rx_trig, 0);
        sup_fine_rx = 1'b0; rx_nib = 4'd0;

        // R12 DMA requests
        wr(8'h29); tick();
        chk("R12 both", dma_req_n, 0);
        sup_dma_ext = 1'b1; #1;
        chk("R12 masked", dma_req_n, 3);
        sup_dma_ext = 1'b0;
        wr(8'hA9); tick();
        chk("R12 tx only", dma_req_n, 2);

        // R4 flush requests
        wr(8'h23); tick();
        chk("R4 rx empty", rx_level, 0);
        chk("R4 tx kept", tx_free, 44);
        wr(8'h21); tick();
        chk("R4 zero no effect", tx_free, 44);
        wr(8'h25); tick();
        chk("R4 tx empty", tx_free, 64);

        // R5 enable toggle flushes both
        for (int i = 0; i < 3; i++) rx_put(8'h30 + 8'(i));
        tx_push = 1'b1; tick(); tick(); tx_push = 1'b0;
        wr(8'h20); tick();
        chk("R5 rx", rx_level, 0);
        chk("R5 tx", tx_free, 1);
        chk("R5 off", fifo_on, 0);

        // R6 one-byte holding register
        rx_put(8'h55);
        rx_put(8'h66);
        chk("R6 shallow", rx_level, 1);
        rx_take();
        rx_take();
        chk("R13 empty pop", rx_level, 0);

        // R13 full 64-entry run
        wr(8'h21); tick();
        for (int i = 0; i < 65; i++) rx_put(8'(i * 3));
        chk("R13 full", rx_level, 64);
        for (int i = 0; i < 64; i++) rx_take();
        chk("R13 drained", rx_level, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule